// File: doc/BRIEF.md
# Loss-of-Clock Supervisor

This block decides which source drives the system clock: the PLL output, a self-clocked fallback oscillator, or nothing (halted). Every cycle it receives one edge-seen indication for the reference clock and one for the PLL feedback clock. It also receives the PLL lock level, a health level for the fallback oscillator, a stop request and two policy enables. A clock is declared lost only after a programmable number of consecutive samples without an edge. The block drives a registered clock-source select, a halt level, a reset request, and two sticky status flags. The flags record clock loss and lock loss.

In run mode a lone reference loss has one of three outcomes. The block requests a reset, moves to the fallback oscillator, or only records the event, depending on the enables. If the reference fails while the PLL is already unhealthy, this counts as a double failure. The fallback oscillator is then latched in until the next reset. If the oscillator cannot run, the block halts. On wake from stop the block waits for the clocks and then returns to the PLL. If lock is missing, it passes through fallback into an unlocked PLL mode. During this recovery, updates to the status flags are deferred until the clocks come back (clock-loss flag) and until lock comes back (lock-loss flag).

Top module: `clkloss_sup`

## Requirements
- R1: While `rst` is high and after it falls, `rst_req` is 1, `clk_sel` is 2'b00 (PLL) and `halt` and both flags are 0. `rst_req` falls only once reference ticks, feedback ticks and `pll_lock` are all present.
- R2: A clock is treated as lost only after LOSS_LIMIT (default 8) consecutive cycles with its tick input low. Gaps of 7 cycles or fewer have no effect on the outputs, and a gap of 8 or more sets `clk_lost_flag`.
- R3: In run mode, when the reference alone is lost and `loss_rst_en` is 1, `rst_req` is high for exactly one cycle. After that `halt` is 1 and `clk_sel` is 2'b10 until reset.
- R4: When the reference alone is lost with `loss_rst_en`=0 and `fallback_en`=1, `clk_sel` becomes 2'b01 (fallback). It returns to 2'b00 when the reference returns. `clk_sel` is a register and changes only together with a state change.
- R5: When the reference alone is lost with both enables 0, `clk_sel` stays 2'b00 and `clk_lost_flag` is set.
- R6: A double failure takes the reference-loss path even when both enables are 0. A double failure is reference loss together with feedback loss or lock loss. With `osc_ok`=1, `clk_sel` becomes 2'b01 and stays there after all clocks return. With `osc_ok`=0, `halt`=1 and `clk_sel`=2'b10 until reset.
- R7: If lock is lost first while the reference is fine, `clk_sel` stays 2'b00 and `lock_lost_flag` is set. A later reference loss latches fallback mode (2'b01), which persists after recovery.
- R8: Suppose all clocks and lock are lost during stop with both enables 0. Then while they stay lost after wake, `halt` is 1, `clk_sel` is 2'b10 and both flags stay 0. When all return, `clk_sel` is 2'b00, `halt` is 0 and both flags are 1.
- R9: Suppose that after stop the feedback clock returns but the reference and lock do not. Then `clk_sel` is 2'b01 even with `fallback_en`=0, and `clk_lost_flag` stays 0. When the reference returns, `clk_sel` is 2'b00 and `clk_lost_flag` is set while `lock_lost_flag` stays 0. `lock_lost_flag` is set only once lock returns.
- R10: If the feedback clock never returns after stop, `halt` stays 1 and `clk_sel` stays 2'b10, even with the reference and lock present.
- R11: The flags are sticky and are cleared by a one-cycle `clr_clk_lost` / `clr_lock_lost` strobe. A clear in a cycle where the set condition still holds leaves the flag at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | Reference edge seen this sample |
| fb_tick | input | 1 | Feedback edge seen this sample |
| pll_lock | input | 1 | PLL lock level |
| osc_ok | input | 1 | Fallback oscillator can run |
| stop_req | input | 1 | Stop-mode request, level |
| fallback_en | input | 1 | Allow switch to fallback on reference loss |
| loss_rst_en | input | 1 | Request reset on reference loss |
| clr_clk_lost | input | 1 | Write-one-to-clear for clock-loss flag |
| clr_lock_lost | input | 1 | Write-one-to-clear for lock-loss flag |
| clk_sel | output | 2 | 00 PLL, 01 fallback, 10 none |
| halt | output | 1 | System frozen / waiting for clocks |
| rst_req | output | 1 | Reset request |
| clk_lost_flag | output | 1 | Sticky clock-loss status |
| lock_lost_flag | output | 1 | Sticky lock-loss status |

## Verification
The hardest situation to reach is the stop-mode recovery where the feedback clock has come back but the reference and lock have not. In that state the block must sit in fallback with the flag updates still deferred. The bench reaches it by stopping the clock ticks and lock while stop is requested, then releasing stop. It restores the feedback ticks first, then the reference, then lock, and checks the select and both flags after each step. The qualification threshold is swept over every gap length from 1 to 12 cycles. The four combinations of the two enables are swept for a lone reference loss.

// File: rtl/clkloss_pkg.sv
package clkloss_pkg;

  typedef enum logic [2:0] {
    ST_NORMAL     = 3'd0,
    ST_FALLBACK   = 3'd1,
    ST_FB_LATCHED = 3'd2,
    ST_STOP       = 3'd3,
    ST_RECOVER    = 3'd4,
    ST_HALT       = 3'd5
  } sup_state_e;

  localparam logic [1:0] SEL_PLL  = 2'b00;
  localparam logic [1:0] SEL_FBK  = 2'b01;
  localparam logic [1:0] SEL_NONE = 2'b10;

  function automatic logic [1:0] sel_for(sup_state_e s);
    case (s)
      ST_FALLBACK, ST_FB_LATCHED: sel_for = SEL_FBK;
      ST_HALT, ST_RECOVER:        sel_for = SEL_NONE;
      default:                    sel_for = SEL_PLL;
    endcase
  endfunction

endpackage

// File: rtl/clkloss_qual.sv
module clkloss_qual #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output logic lost
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] TOP = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  // Starts saturated so a clock must show an edge before it counts as healthy.
  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= TOP;
    else if (tick)        cnt_q <= '0;
    else if (cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
  end

  assign lost = (cnt_q == TOP);
endmodule

// File: rtl/clkloss_fsm.sv
module clkloss_fsm
  import clkloss_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_lost,
  input  logic       fb_lost,
  input  logic       lock_ok,
  input  logic       osc_ok,
  input  logic       stop_req,
  input  logic       fallback_en,
  input  logic       loss_rst_en,
  output sup_state_e state_q,
  output logic       booting,
  output logic [1:0] clk_sel,
  output logic       halt,
  output logic       rst_req
);
  sup_state_e state_d, wake_st;
  logic boot_q, boot_d, pulse;
  logic [1:0] sel_q;
  logic halt_q, rst_q;
  logic pll_bad;

  assign pll_bad = fb_lost | ~lock_ok;

  always_comb begin
    if (fb_lost)                  wake_st = ST_RECOVER;
    else if (!ref_lost && lock_ok) wake_st = ST_NORMAL;
    else                          wake_st = ST_FALLBACK;
  end

  always_comb begin
    state_d = state_q;
    boot_d  = boot_q;
    pulse   = 1'b0;
    if (boot_q) begin
      if (!ref_lost && !fb_lost && lock_ok) boot_d = 1'b0;
    end else begin
      case (state_q)
        ST_NORMAL: begin
          if (ref_lost && pll_bad)
            state_d = osc_ok ? ST_FB_LATCHED : ST_HALT;
          else if (ref_lost) begin
            if (loss_rst_en) begin
              pulse   = 1'b1;
              state_d = ST_HALT;
            end else if (fallback_en) begin
              state_d = ST_FALLBACK;
            end
          end else if (stop_req) begin
            state_d = ST_STOP;
          end
        end
        ST_FALLBACK: begin
          if (!osc_ok)        state_d = ST_HALT;
          else if (!ref_lost) state_d = ST_NORMAL;
        end
        ST_FB_LATCHED: begin
          if (!osc_ok) state_d = ST_HALT;
        end
        ST_STOP: begin
          if (!stop_req) state_d = wake_st;
        end
        ST_RECOVER: state_d = wake_st;
        default:    state_d = ST_HALT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_NORMAL;
      boot_q  <= 1'b1;
      sel_q   <= SEL_PLL;
      halt_q  <= 1'b0;
      rst_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      boot_q  <= boot_d;
      sel_q   <= sel_for(state_d);
      halt_q  <= (state_d == ST_HALT) || (state_d == ST_RECOVER);
      rst_q   <= boot_d | pulse;
    end
  end

  assign booting = boot_q;
  assign clk_sel = sel_q;
  assign halt    = halt_q;
  assign rst_req = rst_q;
endmodule

// File: rtl/clkloss_flags.sv
module clkloss_flags (
  input  logic clk,
  input  logic rst,
  input  logic booting,
  input  logic in_stop,
  input  logic ref_lost,
  input  logic fb_lost,
  input  logic lock_ok,
  input  logic clr_clk_lost,
  input  logic clr_lock_lost,
  output logic clk_lost_flag,
  output logic lock_lost_flag
);
  logic clk_bad, rec_q, rec_act;
  logic pend_clk_q, pend_lock_q;
  logic set_clk, set_lock;
  logic clk_flag_q, lock_flag_q;

  assign clk_bad = ref_lost | fb_lost;
  assign rec_act = in_stop | rec_q;

  always_comb begin
    set_clk  = 1'b0;
    set_lock = 1'b0;
    if (!booting) begin
      if (rec_act) begin
        set_clk  = pend_clk_q && !clk_bad;
        set_lock = pend_lock_q && lock_ok;
      end else begin
        set_clk  = clk_bad;
        set_lock = !lock_ok;
      end
    end
  end

  // Recovery window opens at stop and closes once clocks and lock are all back.
  always_ff @(posedge clk) begin
    if (rst)                                   rec_q <= 1'b0;
    else if (in_stop)                          rec_q <= 1'b1;
    else if (rec_q && !clk_bad && lock_ok)     rec_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || !rec_act) begin
      pend_clk_q  <= 1'b0;
      pend_lock_q <= 1'b0;
    end else begin
      if (set_clk)       pend_clk_q <= 1'b0;
      else if (clk_bad)  pend_clk_q <= 1'b1;
      if (set_lock)      pend_lock_q <= 1'b0;
      else if (!lock_ok) pend_lock_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_flag_q  <= 1'b0;
      lock_flag_q <= 1'b0;
    end else begin
      if (set_clk)           clk_flag_q <= 1'b1;
      else if (clr_clk_lost) clk_flag_q <= 1'b0;
      if (set_lock)           lock_flag_q <= 1'b1;
      else if (clr_lock_lost) lock_flag_q <= 1'b0;
    end
  end

  assign clk_lost_flag  = clk_flag_q;
  assign lock_lost_flag = lock_flag_q;
endmodule

// File: rtl/clkloss_sup.sv
module clkloss_sup
  import clkloss_pkg::*;
#(
  parameter int LOSS_LIMIT = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_tick,
  input  logic       fb_tick,
  input  logic       pll_lock,
  input  logic       osc_ok,
  input  logic       stop_req,
  input  logic       fallback_en,
  input  logic       loss_rst_en,
  input  logic       clr_clk_lost,
  input  logic       clr_lock_lost,
  output logic [1:0] clk_sel,
  output logic       halt,
  output logic       rst_req,
  output logic       clk_lost_flag,
  output logic       lock_lost_flag
);
  localparam int NUM_MON = 2;

  logic [NUM_MON-1:0] tick_v, lost_v;
  sup_state_e state_q;
  logic booting;

  assign tick_v = {fb_tick, ref_tick};

  for (genvar g = 0; g < NUM_MON; g++) begin : g_qual
    clkloss_qual #(.LIMIT(LOSS_LIMIT)) u_qual (
      .clk  (clk),
      .rst  (rst),
      .tick (tick_v[g]),
      .lost (lost_v[g])
    );
  end

  clkloss_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .ref_lost    (lost_v[0]),
    .fb_lost     (lost_v[1]),
    .lock_ok     (pll_lock),
    .osc_ok      (osc_ok),
    .stop_req    (stop_req),
    .fallback_en (fallback_en),
    .loss_rst_en (loss_rst_en),
    .state_q     (state_q),
    .booting     (booting),
    .clk_sel     (clk_sel),
    .halt        (halt),
    .rst_req     (rst_req)
  );

  clkloss_flags u_flags (
    .clk            (clk),
    .rst            (rst),
    .booting        (booting),
    .in_stop        (state_q == ST_STOP),
    .ref_lost       (lost_v[0]),
    .fb_lost        (lost_v[1]),
    .lock_ok        (pll_lock),
    .clr_clk_lost   (clr_clk_lost),
    .clr_lock_lost  (clr_lock_lost),
    .clk_lost_flag  (clk_lost_flag),
    .lock_lost_flag (lock_lost_flag)
  );
endmodule

// File: rtl/clkloss_sup_chk.sv
module clkloss_sup_chk
  import clkloss_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input sup_state_e state_q,
  input logic [1:0] clk_sel,
  input logic       halt,
  input logic       clr_clk_lost,
  input logic       clr_lock_lost,
  input logic       clk_lost_flag,
  input logic       lock_lost_flag
);
  AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HALT) |=> (state_q == ST_HALT)); // R3

  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FB_LATCHED) |=> (state_q == ST_FB_LATCHED || state_q == ST_HALT)); // R6

  AST_SEL_WITH_STATE: assert property (@(posedge clk) disable iff (rst)
    !$stable(clk_sel) |-> !$stable(state_q)); // R4

  AST_HALT_NO_CLK: assert property (@(posedge clk) disable iff (rst)
    halt |-> (clk_sel == SEL_NONE)); // R10

  AST_CLK_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (clk_lost_flag && !clr_clk_lost) |=> clk_lost_flag); // R11

  AST_LOCK_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (lock_lost_flag && !clr_lock_lost) |=> lock_lost_flag); // R11
endmodule

bind clkloss_sup clkloss_sup_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .state_q        (state_q),
  .clk_sel        (clk_sel),
  .halt           (halt),
  .clr_clk_lost   (clr_clk_lost),
  .clr_lock_lost  (clr_lock_lost),
  .clk_lost_flag  (clk_lost_flag),
  .lock_lost_flag (lock_lost_flag)
);

// File: tb/clkloss_sup_tb_top.sv
module clkloss_sup_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_on = 1'b1, fb_on = 1'b1, pll_lock = 1'b1, osc_ok = 1'b1;
  logic stop_req = 1'b0, fallback_en = 1'b0, loss_rst_en = 1'b0;
  logic clr_clk_lost = 1'b0, clr_lock_lost = 1'b0;
  logic [1:0] clk_sel;
  logic halt, rst_req, clk_lost_flag, lock_lost_flag;
  int nchk = 0, nfail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  clkloss_sup #(.LOSS_LIMIT(8)) dut_i (
    .clk(clk), .rst(rst), .ref_tick(ref_on), .fb_tick(fb_on), .pll_lock(pll_lock),
    .osc_ok(osc_ok), .stop_req(stop_req), .fallback_en(fallback_en),
    .loss_rst_en(loss_rst_en), .clr_clk_lost(clr_clk_lost), .clr_lock_lost(clr_lock_lost),
    .clk_sel(clk_sel), .halt(halt), .rst_req(rst_req),
    .clk_lost_flag(clk_lost_flag), .lock_lost_flag(lock_lost_flag)
  );

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(int act, int exp, string tag);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic boot(logic fen, logic ren);
    rst = 1'b1; ref_on = 1'b1; fb_on = 1'b1; pll_lock = 1'b1; osc_ok = 1'b1;
    stop_req = 1'b0; fallback_en = fen; loss_rst_en = ren;
    clr_clk_lost = 1'b0; clr_lock_lost = 1'b0;
    cyc(3);
    rst = 1'b0;
    cyc(4);
  endtask

  task automatic pulse_clr_clk();
    clr_clk_lost = 1'b1; cyc(1); clr_clk_lost = 1'b0; cyc(1);
  endtask

  initial begin
    int hi;
    // R1: reset values and boot hold
    rst = 1'b1; ref_on = 1'b0; cyc(3);
    chk(rst_req, 1, "R1 rst_req in reset");
    chk(clk_sel, 0, "R1 clk_sel in reset");
    chk(halt, 0, "R1 halt in reset");
    chk(clk_lost_flag + lock_lost_flag, 0, "R1 flags in reset");
    rst = 1'b0; cyc(20);
    chk(rst_req, 1, "R1 rst_req held without reference");
    ref_on = 1'b1; cyc(4);
    chk(rst_req, 0, "R1 rst_req released when healthy");
    chk(clk_lost_flag, 0, "R1 no flag from boot");

    // R2: sweep gap length
    for (int gap = 1; gap <= 12; gap++) begin
      boot(1'b0, 1'b0);
      ref_on = 1'b0; cyc(gap); ref_on = 1'b1; cyc(4);
      chk(clk_lost_flag, (gap >= 8) ? 1 : 0, $sformatf("R2 gap %0d", gap));
      chk(clk_sel, 0, "R2 select unchanged");
    end

    // R3 R4 R5: lone reference loss, all enable combinations
    for (int m = 0; m < 4; m++) begin
      boot(m[0], m[1]);
      ref_on = 1'b0; hi = 0;
      for (int c = 0; c < 20; c++) begin cyc(1); hi += rst_req; end
      if (m[1]) begin
        chk(hi, 1, "R3 one-cycle reset request");
        chk(halt, 1, "R3 halt after request");
        chk(clk_sel, 2, "R3 select none");
        ref_on = 1'b1; cyc(10);
        chk(halt, 1, "R3 halt stays");
      end else if (m[0]) begin
        chk(hi, 0, "R4 no reset request");
        chk(clk_sel, 1, "R4 fallback selected");
        ref_on = 1'b1; cyc(4);
        chk(clk_sel, 0, "R4 back to PLL");
      end else begin
        chk(hi, 0, "R5 no reset request");
        chk(clk_sel, 0, "R5 PLL kept");
        chk(clk_lost_flag, 1, "R5 flag set");
      end
    end

    // R6: double failure, oscillator healthy
    boot(1'b0, 1'b0);
    ref_on = 1'b0; fb_on = 1'b0; pll_lock = 1'b0; cyc(12);
    chk(clk_sel, 1, "R6 latched fallback");
    chk(rst_req, 0, "R6 no reset request");
    ref_on = 1'b1; fb_on = 1'b1; pll_lock = 1'b1; cyc(12);
    chk(clk_sel, 1, "R6 latch ignores recovery");
    // R6: double failure, oscillator dead
    boot(1'b1, 1'b1);
    osc_ok = 1'b0; ref_on = 1'b0; fb_on = 1'b0; cyc(12);
    chk(halt, 1, "R6 halt without oscillator");
    chk(clk_sel, 2, "R6 select none");
    chk(rst_req, 0, "R6 reference-loss reset not taken");
    ref_on = 1'b1; fb_on = 1'b1; osc_ok = 1'b1; cyc(12);
    chk(halt, 1, "R6 halt frozen");

    // R7: lock lost first, then reference
    boot(1'b0, 1'b0);
    pll_lock = 1'b0; cyc(5);
    chk(clk_sel, 0, "R7 PLL kept on lock loss");
    chk(lock_lost_flag, 1, "R7 lock flag");
    ref_on = 1'b0; cyc(12);
    chk(clk_sel, 1, "R7 latched fallback");
    ref_on = 1'b1; pll_lock = 1'b1; cyc(12);
    chk(clk_sel, 1, "R7 latch persists");

    // R8: stop, everything lost, then all return
    boot(1'b0, 1'b0);
    stop_req = 1'b1; cyc(2);
    ref_on = 1'b0; fb_on = 1'b0; pll_lock = 1'b0; cyc(12);
    chk(clk_lost_flag + lock_lost_flag, 0, "R8 flags held in stop");
    stop_req = 1'b0; cyc(6);
    chk(halt, 1, "R8 stuck halt");
    chk(clk_sel, 2, "R8 select none");
    chk(clk_lost_flag + lock_lost_flag, 0, "R8 flags held while lost");
    ref_on = 1'b1; fb_on = 1'b1; pll_lock = 1'b1; cyc(4);
    chk(clk_sel, 0, "R8 PLL resumed");
    chk(halt, 0, "R8 halt released");
    chk(clk_lost_flag, 1, "R8 clock flag");
    chk(lock_lost_flag, 1, "R8 lock flag");

    // R9: feedback back first, then reference, then lock
    boot(1'b0, 1'b0);
    stop_req = 1'b1; cyc(2);
    ref_on = 1'b0; fb_on = 1'b0; pll_lock = 1'b0; cyc(12);
    stop_req = 1'b0; cyc(3);
    fb_on = 1'b1; cyc(4);
    chk(clk_sel, 1, "R9 fallback despite enable clear");
    chk(clk_lost_flag, 0, "R9 clock flag deferred");
    ref_on = 1'b1; cyc(4);
    chk(clk_sel, 0, "R9 unlocked PLL mode");
    chk(clk_lost_flag, 1, "R9 clock flag on return");
    chk(lock_lost_flag, 0, "R9 lock flag deferred");
    pll_lock = 1'b1; cyc(3);
    chk(lock_lost_flag, 1, "R9 lock flag on lock");

    // R10: feedback never returns
    boot(1'b0, 1'b0);
    stop_req = 1'b1; cyc(2);
    fb_on = 1'b0; ref_on = 1'b0; cyc(12);
    stop_req = 1'b0; ref_on = 1'b1; cyc(30);
    chk(halt, 1, "R10 halt stays");
    chk(clk_sel, 2, "R10 select none");

    // R11: set wins over clear, then clear works
    boot(1'b0, 1'b0);
    ref_on = 1'b0; cyc(12);
    pulse_clr_clk();
    chk(clk_lost_flag, 1, "R11 set beats clear");
    ref_on = 1'b1; cyc(3);
    pulse_clr_clk();
    chk(clk_lost_flag, 0, "R11 clear");
    pll_lock = 1'b0; cyc(2); pll_lock = 1'b1; cyc(2);
    clr_lock_lost = 1'b1; cyc(1); clr_lock_lost = 1'b0; cyc(1);
    chk(lock_lost_flag, 0, "R11 lock flag clear");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule